// File: doc/BRIEF.md
# Graphics DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a graphics DDR SDRAM interface. It takes the memory from a cold, unpowered state to a state where normal traffic may begin. While power is not yet good, it holds the memory's reset and clock enable low and drives DESELECT. Once power is good, it waits out the stable-power and stable-clock intervals. It then issues one NOP and releases reset. The clock-enable level around that reset edge selects the memory's address and command termination strength. After that the sequencer raises clock enable and issues the fixed list of setup commands: PRECHARGE ALL, the extended mode load that enables the DLL, the mode load that resets the DLL and carries the operating settings, a second PRECHARGE ALL, and a burst of AUTO REFRESH commands that calibrate the output drivers.

Every interval is a parameter given in clock cycles. All intervals are timed by one shared down-counter, which is loaded each time a new state is entered. The DLL lock interval runs from the mode load. When the refresh gaps end before that interval does, the machine waits out the remainder in a dedicated lock state. A completion flag then rises and stays high for as long as power stays good. If power-good falls at any point, the machine returns to the unpowered state, and the sequence restarts from the beginning when power-good returns.

States: `ST_OFF` moves to `ST_PWR_WAIT` when power is good. `ST_PWR_WAIT` moves to `ST_NOP` when its wait expires. `ST_NOP` always moves to `ST_RST_REL`. `ST_RST_REL` moves to `ST_PRE1` when its hold expires. `ST_PRE1` moves to `ST_TRP1`, which moves to `ST_EMRS` when its wait expires. `ST_EMRS` moves to `ST_TMRD1`, which moves to `ST_MRS` when its wait expires. `ST_MRS` moves to `ST_TMRD2`, which moves to `ST_PRE2` when its wait expires. `ST_PRE2` moves to `ST_TRP2`, which moves to `ST_REF` when its wait expires. `ST_REF` moves to `ST_TRFC`. When `ST_TRFC` expires, the machine goes back to `ST_REF` if refreshes remain. Otherwise it goes to `ST_LOCK` if lock time remains, or else to `ST_DONE`. `ST_LOCK` moves to `ST_DONE` when it expires. `ST_DONE` holds. From every state, a low power-good moves the machine to `ST_OFF`.

Top module: `gddr_init_seq`

## Requirements
- R1: After system reset, and on every cycle while power-good is low: mem_rst_n=0, mem_cke=0, the command is DESELECT (cs_n,ras_n,cas_n,we_n = 1111), mem_ba=0, mem_addr=0 and init_done=0.
- R2: After power-good is sampled high, the R1 outputs hold for exactly max(T_PWR_CYC, T_CMD_CYC) cycles.
- R3: The next cycle is a single NOP (0111) with mem_rst_n still 0 and mem_cke equal to TERM_FULL.
- R4: mem_rst_n then rises, and mem_cke stays at TERM_FULL for T_HOLD_CYC cycles, both edges included, so the termination select is stable around the reset edge. After that, mem_cke is 1.
- R5: The executable commands come in this order: PRECHARGE (0010), a mode load (0000) with mem_ba=01, a mode load with mem_ba=00, PRECHARGE, then exactly REF_COUNT AUTO REFRESH (0001).
- R6: Each PRECHARGE drives mem_addr bit 8 high and all other address bits low. The mem_ba=01 load carries EMR_CODE and the mem_ba=00 load carries MR_CODE on mem_addr.
- R7: Exactly T_RP_CYC NOP cycles follow each PRECHARGE, T_MRD_CYC follow each mode load and T_RFC_CYC follow each refresh.
- R8: init_done first rises max(E, DLL_LOCK_CYC) cycles after the mem_ba=00 mode load cycle, where E = 2 + T_MRD_CYC + T_RP_CYC + REF_COUNT*(1+T_RFC_CYC) covers the end of the last refresh gap. Until then only NOP is driven.
- R9: Once high, init_done stays high, with NOP, mem_rst_n=1 and mem_cke=1, for as long as power-good stays high.
- R10: A low power-good in any state gives the R1 outputs on the next cycle. When power-good returns, the sequence restarts from R2.
- R11: After reset release, every non-command cycle is NOP and never DESELECT. No executable command appears while mem_rst_n or mem_cke is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; all intervals are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| pwr_good | input | 1 | High while memory supplies and clock are stable |
| mem_rst_n | output | 1 | Reset to the memory, active low |
| mem_cke | output | 1 | Clock enable to the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | 2 | Bank address; selects which mode register a load targets |
| mem_addr | output | ADDR_W | Address; carries mode codes and the all-banks bit |
| init_done | output | 1 | High once initialization and DLL lock are complete |

## Verification
The power-good monitor can act in the same cycle in which a wait expires and a command would be issued, or in the same cycle in which init_done would first rise. The bench provokes these collisions by dropping power-good at exactly the PRECHARGE cycle, at the init_done cycle, and at cycles drawn at random across the whole sequence. It judges each case by checking that the following cycle shows the reset-low DESELECT outputs rather than the scheduled command. Two parameter sets are used: one where the DLL lock interval outlasts the refreshes and one where it does not, with opposite termination levels.

// File: rtl/gi_pkg.sv
package gi_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_PWR_WAIT,
        ST_NOP,
        ST_RST_REL,
        ST_PRE1,
        ST_TRP1,
        ST_EMRS,
        ST_TMRD1,
        ST_MRS,
        ST_TMRD2,
        ST_PRE2,
        ST_TRP2,
        ST_REF,
        ST_TRFC,
        ST_LOCK,
        ST_DONE
    } gi_state_e;

    // command bits are {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_DESEL = 4'b1111,
        CMD_NOP   = 4'b0111,
        CMD_PRE   = 4'b0010,
        CMD_MRS   = 4'b0000,
        CMD_REF   = 4'b0001
    } gi_cmd_e;

    function automatic int gi_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/gi_delay_ctr.sv
module gi_delay_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R7: an unloaded running count steps down by exactly one per cycle
    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R7: an expired, unloaded counter stays expired
    p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && expired) |=> expired);

endmodule

// File: rtl/gi_fsm.sv
module gi_fsm
    import gi_pkg::*;
#(
    parameter int T_WAIT    = 40000,
    parameter int T_HOLD    = 2,
    parameter int T_RP      = 4,
    parameter int T_MRD     = 4,
    parameter int T_RFC     = 20,
    parameter int LOCK_REM  = 0,
    parameter int REF_COUNT = 2,
    parameter int CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_good,
    input  logic             cnt_expired,
    output gi_state_e        state_q,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val
);
    localparam int REF_W = $clog2(REF_COUNT + 1);

    gi_state_e        state_d;
    logic [REF_W-1:0] ref_q;

    function automatic int dwell(input gi_state_e s);
        case (s)
            ST_PWR_WAIT: return T_WAIT;
            ST_RST_REL:  return T_HOLD;
            ST_TRP1:     return T_RP;
            ST_TRP2:     return T_RP;
            ST_TMRD1:    return T_MRD;
            ST_TMRD2:    return T_MRD;
            ST_TRFC:     return T_RFC;
            ST_LOCK:     return LOCK_REM;
            default:     return 1;
        endcase
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q <= '0;
        end else if (state_q == ST_OFF) begin
            ref_q <= '0;
        end else if (state_q == ST_REF) begin
            ref_q <= ref_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:      state_d = ST_PWR_WAIT;
            ST_PWR_WAIT: if (cnt_expired) state_d = ST_NOP;
            ST_NOP:      state_d = ST_RST_REL;
            ST_RST_REL:  if (cnt_expired) state_d = ST_PRE1;
            ST_PRE1:     state_d = ST_TRP1;
            ST_TRP1:     if (cnt_expired) state_d = ST_EMRS;
            ST_EMRS:     state_d = ST_TMRD1;
            ST_TMRD1:    if (cnt_expired) state_d = ST_MRS;
            ST_MRS:      state_d = ST_TMRD2;
            ST_TMRD2:    if (cnt_expired) state_d = ST_PRE2;
            ST_PRE2:     state_d = ST_TRP2;
            ST_TRP2:     if (cnt_expired) state_d = ST_REF;
            ST_REF:      state_d = ST_TRFC;
            ST_TRFC: begin
                if (cnt_expired) begin
                    if (ref_q != REF_W'(REF_COUNT)) begin
                        state_d = ST_REF;
                    end else if (LOCK_REM > 0) begin
                        state_d = ST_LOCK;
                    end else begin
                        state_d = ST_DONE;
                    end
                end
            end
            ST_LOCK:     if (cnt_expired) state_d = ST_DONE;
            ST_DONE:     state_d = ST_DONE;
        endcase
        if (!pwr_good) begin
            state_d = ST_OFF;
        end
    end

    assign cnt_load = (state_d != state_q);
    assign cnt_val  = CNT_W'(dwell(state_d) - 1);

    // R10: power-good low forces the off state on the next cycle
    p_pg_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (state_q == ST_OFF));

    // R5: never more refreshes than configured
    p_ref_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ref_q <= REF_W'(REF_COUNT));

    // R8: completion is reached only after all refreshes were issued
    p_done_after_refs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_DONE && state_d == ST_DONE) |-> (ref_q == REF_W'(REF_COUNT)));

endmodule

// File: rtl/gi_cmd_out.sv
module gi_cmd_out
    import gi_pkg::*;
#(
    parameter int              ADDR_W    = 12,
    parameter int              ALL_BIT   = 8,
    parameter logic            TERM_FULL = 1'b1,
    parameter logic [ADDR_W-1:0] MR_CODE  = '0,
    parameter logic [ADDR_W-1:0] EMR_CODE = '0
) (
    input  gi_state_e         state_q,
    output gi_cmd_e           cmd,
    output logic [1:0]        ba,
    output logic [ADDR_W-1:0] addr,
    output logic              mem_rst_n,
    output logic              mem_cke,
    output logic              done
);
    localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << ALL_BIT;

    always_comb begin
        cmd       = CMD_NOP;
        ba        = 2'b00;
        addr      = '0;
        mem_rst_n = 1'b1;
        mem_cke   = 1'b1;
        done      = 1'b0;
        unique case (state_q)
            ST_OFF, ST_PWR_WAIT: begin
                cmd       = CMD_DESEL;
                mem_rst_n = 1'b0;
                mem_cke   = 1'b0;
            end
            ST_NOP: begin
                mem_rst_n = 1'b0;
                mem_cke   = TERM_FULL;
            end
            ST_RST_REL: begin
                mem_cke   = TERM_FULL;
            end
            ST_PRE1, ST_PRE2: begin
                cmd  = CMD_PRE;
                addr = ALL_BANKS;
            end
            ST_EMRS: begin
                cmd  = CMD_MRS;
                ba   = 2'b01;
                addr = EMR_CODE;
            end
            ST_MRS: begin
                cmd  = CMD_MRS;
                ba   = 2'b00;
                addr = MR_CODE;
            end
            ST_REF: begin
                cmd = CMD_REF;
            end
            ST_DONE: begin
                done = 1'b1;
            end
            ST_TRP1, ST_TMRD1, ST_TMRD2, ST_TRP2, ST_TRFC, ST_LOCK: begin
                cmd = CMD_NOP;
            end
        endcase
    end

endmodule

// File: rtl/gddr_init_seq.sv
module gddr_init_seq
    import gi_pkg::*;
#(
    parameter int                T_PWR_CYC    = 20000,
    parameter int                T_CMD_CYC    = 40000,
    parameter int                T_HOLD_CYC   = 2,
    parameter int                T_RP_CYC     = 4,
    parameter int                T_MRD_CYC    = 4,
    parameter int                T_RFC_CYC    = 20,
    parameter int                DLL_LOCK_CYC = 20000,
    parameter int                REF_COUNT    = 2,
    parameter logic              TERM_FULL    = 1'b1,
    parameter int                ADDR_W       = 12,
    parameter logic [ADDR_W-1:0] MR_CODE      = 12'h132,
    parameter logic [ADDR_W-1:0] EMR_CODE     = 12'h040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    output logic              mem_rst_n,
    output logic              mem_cke,
    output logic              mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [1:0]        mem_ba,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              init_done
);
    localparam int T_WAIT   = gi_max(T_PWR_CYC, T_CMD_CYC);
    localparam int E_SPAN   = 2 + T_MRD_CYC + T_RP_CYC + REF_COUNT * (1 + T_RFC_CYC);
    localparam int LOCK_REM = (DLL_LOCK_CYC > E_SPAN) ? (DLL_LOCK_CYC - E_SPAN) : 0;
    localparam int MAX_D    = gi_max(gi_max(gi_max(T_WAIT, T_HOLD_CYC), gi_max(T_RP_CYC, T_MRD_CYC)),
                                     gi_max(T_RFC_CYC, LOCK_REM));
    localparam int CNT_W    = $clog2(MAX_D + 1);
    localparam int ALL_BIT  = 8;

    gi_state_e        state_q;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_expired;
    gi_cmd_e          cmd;

    gi_delay_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .expired  (cnt_expired)
    );

    gi_fsm #(
        .T_WAIT    (T_WAIT),
        .T_HOLD    (T_HOLD_CYC),
        .T_RP      (T_RP_CYC),
        .T_MRD     (T_MRD_CYC),
        .T_RFC     (T_RFC_CYC),
        .LOCK_REM  (LOCK_REM),
        .REF_COUNT (REF_COUNT),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_good    (pwr_good),
        .cnt_expired (cnt_expired),
        .state_q     (state_q),
        .cnt_load    (cnt_load),
        .cnt_val     (cnt_val)
    );

    gi_cmd_out #(
        .ADDR_W    (ADDR_W),
        .ALL_BIT   (ALL_BIT),
        .TERM_FULL (TERM_FULL),
        .MR_CODE   (MR_CODE),
        .EMR_CODE  (EMR_CODE)
    ) u_out (
        .state_q   (state_q),
        .cmd       (cmd),
        .ba        (mem_ba),
        .addr      (mem_addr),
        .mem_rst_n (mem_rst_n),
        .mem_cke   (mem_cke),
        .done      (init_done)
    );

    assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd;

    // R4: the clock-enable level at the reset rising edge is the termination select
    p_term_at_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rst_n) |-> (mem_cke == TERM_FULL));

    // R11: executable commands only with reset released and clock enabled
    p_cmd_needs_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !(mem_ras_n && mem_cas_n && mem_we_n)) |-> (mem_rst_n && mem_cke));

    // R6: every precharge addresses all banks
    p_pre_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) |-> mem_addr[ALL_BIT]);

    // R9: completion holds while power stays good
    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done && pwr_good) |=> init_done);

    // R1: no completion without the memory out of reset
    p_done_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (mem_rst_n && mem_cke && !pwr_good == 1'b0 || !pwr_good));

endmodule

// File: tb/gddr_init_seq_test.sv
`timescale 1ns/1ps
module gddr_init_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pg = 2'b00;
    int         checks = 0;
    int         errors = 0;

    always #2.5 clk = ~clk;

    logic        a_rst, a_cke, a_cs, a_ras, a_cas, a_we, a_done;
    logic [1:0]  a_ba;
    logic [11:0] a_addr;
    logic        b_rst, b_cke, b_cs, b_ras, b_cas, b_we, b_done;
    logic [1:0]  b_ba;
    logic [11:0] b_addr;

    gddr_init_seq #(
        .T_PWR_CYC(5), .T_CMD_CYC(8), .T_HOLD_CYC(2), .T_RP_CYC(3), .T_MRD_CYC(2),
        .T_RFC_CYC(4), .DLL_LOCK_CYC(40), .REF_COUNT(2), .TERM_FULL(1'b0),
        .ADDR_W(12), .MR_CODE(12'h123), .EMR_CODE(12'h044)
    ) uut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pg[0]),
        .mem_rst_n(a_rst), .mem_cke(a_cke), .mem_cs_n(a_cs), .mem_ras_n(a_ras),
        .mem_cas_n(a_cas), .mem_we_n(a_we), .mem_ba(a_ba), .mem_addr(a_addr),
        .init_done(a_done)
    );

    gddr_init_seq #(
        .T_PWR_CYC(9), .T_CMD_CYC(6), .T_HOLD_CYC(1), .T_RP_CYC(2), .T_MRD_CYC(3),
        .T_RFC_CYC(2), .DLL_LOCK_CYC(10), .REF_COUNT(3), .TERM_FULL(1'b1),
        .ADDR_W(12), .MR_CODE(12'h5A1), .EMR_CODE(12'h008)
    ) uut_b (
        .clk(clk), .rst_n(rst_n), .pwr_good(pg[1]),
        .mem_rst_n(b_rst), .mem_cke(b_cke), .mem_cs_n(b_cs), .mem_ras_n(b_ras),
        .mem_cas_n(b_cas), .mem_we_n(b_we), .mem_ba(b_ba), .mem_addr(b_addr),
        .init_done(b_done)
    );

    wire [20:0] obs_a = {a_rst, a_cke, a_cs, a_ras, a_cas, a_we, a_ba, a_addr, a_done};
    wire [20:0] obs_b = {b_rst, b_cke, b_cs, b_ras, b_cas, b_we, b_ba, b_addr, b_done};

    // per-unit parameters
    function automatic int p_wait(int u); return (u == 0) ? 8 : 9; endfunction
    function automatic int p_hold(int u); return (u == 0) ? 2 : 1; endfunction
    function automatic int p_rp(int u);   return (u == 0) ? 3 : 2; endfunction
    function automatic int p_mrd(int u);  return (u == 0) ? 2 : 3; endfunction
    function automatic int p_rfc(int u);  return (u == 0) ? 4 : 2; endfunction
    function automatic int p_dll(int u);  return (u == 0) ? 40 : 10; endfunction
    function automatic int p_nref(int u); return (u == 0) ? 2 : 3; endfunction
    function automatic logic p_term(int u); return (u == 0) ? 1'b0 : 1'b1; endfunction
    function automatic logic [11:0] p_mr(int u);  return (u == 0) ? 12'h123 : 12'h5A1; endfunction
    function automatic logic [11:0] p_emr(int u); return (u == 0) ? 12'h044 : 12'h008; endfunction

    function automatic int c_pre1(int u); return p_wait(u) + p_hold(u) + 1; endfunction
    function automatic int c_mrs(int u);  return c_pre1(u) + 2 + p_rp(u) + p_mrd(u); endfunction
    function automatic int c_span(int u);
        return 2 + p_mrd(u) + p_rp(u) + p_nref(u) * (1 + p_rfc(u));
    endfunction
    function automatic int c_done(int u);
        return c_mrs(u) + ((p_dll(u) > c_span(u)) ? p_dll(u) : c_span(u));
    endfunction

    localparam logic [20:0] OFF_V = {2'b00, 4'b1111, 2'b00, 12'h000, 1'b0};

    // expected {rst,cke,cs,ras,cas,we,ba,addr,done} k cycles after power-good is taken
    function automatic logic [20:0] expect_at(int u, int k);
        int w = p_wait(u);
        int m = c_mrs(u);
        int r0 = m + 2 + p_mrd(u) + p_rp(u);
        logic [20:0] v = {2'b11, 4'b0111, 2'b00, 12'h000, 1'b0};
        if (k < w) return OFF_V;
        if (k == w) return {1'b0, p_term(u), 4'b0111, 2'b00, 12'h000, 1'b0};
        if (k <= w + p_hold(u)) return {1'b1, p_term(u), 4'b0111, 2'b00, 12'h000, 1'b0};
        if (k == c_pre1(u) || k == m + 1 + p_mrd(u))
            v = {2'b11, 4'b0010, 2'b00, 12'h100, 1'b0};
        if (k == c_pre1(u) + 1 + p_rp(u))
            v = {2'b11, 4'b0000, 2'b01, p_emr(u), 1'b0};
        if (k == m)
            v = {2'b11, 4'b0000, 2'b00, p_mr(u), 1'b0};
        for (int i = 0; i < p_nref(u); i++)
            if (k == r0 + i * (1 + p_rfc(u))) v = {2'b11, 4'b0001, 2'b00, 12'h000, 1'b0};
        if (k >= c_done(u)) v[0] = 1'b1;
        return v;
    endfunction

    function automatic string tag_at(int u, int k);
        logic [20:0] e = expect_at(u, k);
        if (k < p_wait(u)) return "R2";
        if (k == p_wait(u)) return "R3";
        if (k <= p_wait(u) + p_hold(u)) return "R4";
        if (e[18:15] == 4'b0010 || e[18:15] == 4'b0000) return "R6/R5";
        if (e[18:15] == 4'b0001) return "R5";
        if (k >= c_done(u)) return "R9/R8";
        if (k == c_done(u) - 1) return "R8";
        return "R7/R11";
    endfunction

    function automatic logic [20:0] obs(int u);
        return (u == 0) ? obs_a : obs_b;
    endfunction

    task automatic check(int u, logic [20:0] exp_v, string req);
        checks++;
        if (obs(u) !== exp_v) begin
            errors++;
            $display("FAIL %s unit %0d: actual %h expected %h", req, u, obs(u), exp_v);
        end
    endtask

    // one power-up; drop < 0 means run to completion then power off
    task automatic run(int u, int drop);
        int last = c_done(u) + 6;
        @(negedge clk);
        pg[u] = 1'b1;
        for (int k = 0; k <= last; k++) begin
            @(negedge clk);
            check(u, expect_at(u, k), tag_at(u, k));
            if (k == drop) break;
        end
        pg[u] = 1'b0;
        @(negedge clk);
        check(u, OFF_V, "R10");
        @(negedge clk);
        check(u, OFF_V, "R1");
        repeat (2) @(negedge clk);
    endtask

    initial begin : watchdog
        #(150000 * 5);
        errors++;
        $display("FAIL watchdog expired: actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        check(0, OFF_V, "R1");
        check(1, OFF_V, "R1");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(0, OFF_V, "R1");
        check(1, OFF_V, "R1");

        // directed: full runs, both termination levels and both lock cases (R8)
        run(0, -1);
        run(1, -1);
        // directed: drop on the first precharge cycle (R10 against R5)
        run(0, c_pre1(0));
        run(1, c_pre1(1));
        // directed: drop on the cycle completion first shows (R10 against R8)
        run(0, c_done(0));
        run(1, c_done(1));
        // directed: drop on the very first wait cycle and on the NOP cycle
        run(0, 0);
        run(1, p_wait(1));
        // random drop points
        for (int n = 0; n < 16; n++) begin
            int u = n % 2;
            int d = ($urandom % 4 == 0) ? -1 : int'($urandom % (c_done(u) + 4));
            run(u, d);
        end
        // back-to-back restart after recovery (R10 restart)
        run(0, -1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule